// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block follows a chain of control blocks held in memory. It reads them through a simple 64-bit word read port and hands each data-block entry to a downstream data mover. The walk begins at a start pulse that supplies the address of the first control block, the number of data blocks per control block for this channel, and the channel direction (injection or extraction).

Each control block is a run of consecutive 64-bit words:
- the pointer to the next control block;
- an info word;
- one status word and one buffer pointer for each data block.

The walker fetches the pointer and info words first. For each data block it then fetches the status word and the buffer pointer, and offers the entry on a valid/ready handshake. It does not fetch anything more until that entry has been accepted.

A next pointer of all ones ends the list. The walker then raises a list-refill interrupt pulse and goes idle. Each accepted entry whose end-of-frame bit is set raises a frame interrupt pulse. A misaligned address, or an extraction buffer that breaks the alignment or size rules, sets a sticky error flag and halts the walk.

Top module: `desc_walker`

## Requirements
- R1: After reset, busy, err, rd_req, ent_valid, irq_frame and irq_refill are all low.
- R2: Words of one control block are requested at consecutive 8-byte addresses in this order: next pointer at base+0, info at base+8, then status at base+16+16*i and buffer pointer at base+24+16*i for block i. Every requested address has its low three bits zero.
- R3: The per-channel block count blk_cfg selects 1 to 15 data blocks per control block. A blk_cfg of 0 behaves as 1.
- R4: An entry is offered with ent_valid. While ent_ready is low, ent_valid stays high and ent_ptr, ent_len, ent_eof hold steady. ent_ptr is the low address bits of the pointer word. ent_len is bits [15:0] of the status word. ent_eof is bit 16 of the status word.
- R5: No read is requested while an entry is being offered.
- R6: After the last entry of a control block is accepted, the walker continues at the address held in that block's next-pointer word.
- R7: When the last entry of a block whose next pointer is all ones is accepted, irq_refill pulses for one cycle and busy falls.
- R8: irq_frame pulses for one cycle, exactly once per accepted entry whose end-of-frame bit is set, and never otherwise.
- R9: A start address or next pointer whose low three bits are not zero sets err and halts the walk: busy falls and no further read or entry follows. err stays set until the next start.
- R10: In extraction mode, a buffer pointer whose low three bits are not zero, or a length that is not a multiple of 128, sets err. No entry is offered for that block. Injection mode does not apply these checks.
- R11: A start pulse while busy is ignored. A start pulse while idle or halted clears err and begins a new walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a walk (one-cycle pulse) |
| start_addr | input | AW | Address of the first control block |
| blk_cfg | input | CNT_W | Data blocks per control block (0 behaves as 1) |
| extract | input | 1 | 1 = extraction channel, 0 = injection channel |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Byte address of the requested 64-bit word |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | DW | Returned word |
| ent_valid | output | 1 | Entry offered to the data mover |
| ent_ready | input | 1 | Data mover accepts the entry |
| ent_ptr | output | AW | Buffer pointer of the entry |
| ent_len | output | LEN_W | Buffer length from the status word |
| ent_eof | output | 1 | End-of-frame flag from the status word |
| ent_info | output | DW | Info word of the current control block |
| irq_frame | output | 1 | Frame-completion interrupt pulse |
| irq_refill | output | 1 | List-exhausted interrupt pulse |
| err | output | 1 | Sticky alignment/size error |
| busy | output | 1 | A walk is in progress |

## Verification
The hardest situation to reach is a start pulse that arrives mid-walk. The walker must be held in a known state when the pulse lands. The bench gets there by driving ent_ready low so the walker parks on an offered entry. It then pulses start with a different list address, releases ent_ready, and checks that only the original chain was delivered.

The other hard case is a misaligned next pointer. It appears only after a full control block has been handed out. To reach it, the memory model holds a valid first block whose next-pointer word has bit 2 set.

// File: rtl/desc_walk_pkg.sv
package desc_walk_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_NEXT,
      ST_INFO,
      ST_STAT,
      ST_PTR,
      ST_OUT,
      ST_HALT
   } walk_st_t;

   localparam int unsigned WORD_BYTES_LG = 3;
endpackage

// File: rtl/dw_addr_gen.sv
module dw_addr_gen #(
   parameter int unsigned AW   = 32,
   parameter int unsigned IDXW = 6
) (
   input  logic [AW-1:0]   base,
   input  logic [IDXW-1:0] word_idx,
   output logic [AW-1:0]   addr
);
   localparam int unsigned SH = desc_walk_pkg::WORD_BYTES_LG;

   logic [AW-1:0] offs;

   always_comb begin
      offs = '0;
      offs[IDXW+SH-1:SH] = word_idx;
      addr = base + offs;
   end
endmodule

// File: rtl/dw_check.sv
module dw_check #(
   parameter int unsigned AW            = 32,
   parameter int unsigned LEN_W         = 16,
   parameter int unsigned BLK_BYTES     = 128,
   parameter bit          INJ_ALIGN_CHK = 1'b0
) (
   input  logic             is_ext,
   input  logic [AW-1:0]    ptr,
   input  logic [LEN_W-1:0] len,
   output logic             bad
);
   localparam int unsigned LEN_LSB = $clog2(BLK_BYTES);

   logic ptr_mis;
   logic len_mis;

   assign ptr_mis = |ptr[2:0];
   assign len_mis = |len[LEN_LSB-1:0];

   generate
      if (INJ_ALIGN_CHK) begin : g_both
         assign bad = ptr_mis | (is_ext & len_mis);
      end else begin : g_ext_only
         assign bad = is_ext & (ptr_mis | len_mis);
      end
   endgenerate
endmodule

// File: rtl/dw_out_stage.sv
module dw_out_stage #(
   parameter int unsigned AW      = 32,
   parameter int unsigned DW      = 64,
   parameter int unsigned LEN_W   = 16,
   parameter int unsigned EOF_BIT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [DW-1:0]    ptr_word,
   input  logic [DW-1:0]    stat_word,
   input  logic [DW-1:0]    info_word,
   input  logic             ready,
   output logic             valid,
   output logic [AW-1:0]    ptr,
   output logic [LEN_W-1:0] len,
   output logic             eof,
   output logic [DW-1:0]    info
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         ptr   <= '0;
         len   <= '0;
         eof   <= 1'b0;
         info  <= '0;
      end else if (ld) begin
         valid <= 1'b1;
         ptr   <= ptr_word[AW-1:0];
         len   <= stat_word[LEN_W-1:0];
         eof   <= stat_word[EOF_BIT];
         info  <= info_word;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/desc_walker.sv
module desc_walker #(
   parameter int unsigned AW            = 32,
   parameter int unsigned DW            = 64,
   parameter int unsigned CNT_W         = 4,
   parameter int unsigned LEN_W         = 16,
   parameter int unsigned EOF_BIT       = 16,
   parameter int unsigned BLK_BYTES     = 128,
   parameter bit          INJ_ALIGN_CHK = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AW-1:0]    start_addr,
   input  logic [CNT_W-1:0] blk_cfg,
   input  logic             extract,
   output logic             rd_req,
   output logic [AW-1:0]    rd_addr,
   input  logic             rd_valid,
   input  logic [DW-1:0]    rd_data,
   output logic             ent_valid,
   input  logic             ent_ready,
   output logic [AW-1:0]    ent_ptr,
   output logic [LEN_W-1:0] ent_len,
   output logic             ent_eof,
   output logic [DW-1:0]    ent_info,
   output logic             irq_frame,
   output logic             irq_refill,
   output logic             err,
   output logic             busy
);
   import desc_walk_pkg::*;

   localparam int unsigned IDXW = CNT_W + 2;

   if (DW < AW) begin : g_bad_dw
      $error("desc_walker: DW must be at least AW");
   end
   if (EOF_BIT >= DW || LEN_W > EOF_BIT) begin : g_bad_eof
      $error("desc_walker: EOF_BIT must lie above the length field inside DW");
   end
   if (BLK_BYTES < 2 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_bad_blk
      $error("desc_walker: BLK_BYTES must be a power of two");
   end

   walk_st_t         st;
   logic [AW-1:0]    base;
   logic [AW-1:0]    next_ptr;
   logic [DW-1:0]    info_q;
   logic [DW-1:0]    stat_q;
   logic [CNT_W-1:0] idx;
   logic [CNT_W-1:0] nblk;
   logic             ext_q;
   logic             req_sent;
   logic [IDXW-1:0]  word_idx;
   logic             fetching;
   logic             got;
   logic             blk_bad;
   logic             ld_ent;
   logic             acc;
   logic             last_blk;

   assign fetching = (st == ST_NEXT) || (st == ST_INFO) || (st == ST_STAT) || (st == ST_PTR);
   assign rd_req   = fetching && !req_sent;
   assign got      = fetching && req_sent && rd_valid;
   assign acc      = ent_valid && ent_ready;
   assign last_blk = (idx == nblk - 1'b1);
   assign busy     = (st != ST_IDLE) && (st != ST_HALT);

   always_comb begin
      unique case (st)
         ST_INFO: word_idx = IDXW'(1);
         ST_STAT: word_idx = IDXW'({idx, 1'b0}) + IDXW'(2);
         ST_PTR:  word_idx = IDXW'({idx, 1'b0}) + IDXW'(3);
         default: word_idx = '0;
      endcase
   end

   dw_addr_gen #(.AW(AW), .IDXW(IDXW)) u_addr (
      .base     (base),
      .word_idx (word_idx),
      .addr     (rd_addr)
   );

   dw_check #(
      .AW(AW), .LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES), .INJ_ALIGN_CHK(INJ_ALIGN_CHK)
   ) u_chk_blk (
      .is_ext (ext_q),
      .ptr    (rd_data[AW-1:0]),
      .len    (stat_q[LEN_W-1:0]),
      .bad    (blk_bad)
   );

   assign ld_ent = got && (st == ST_PTR) && !blk_bad;

   dw_out_stage #(
      .AW(AW), .DW(DW), .LEN_W(LEN_W), .EOF_BIT(EOF_BIT)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (ld_ent),
      .ptr_word  (rd_data),
      .stat_word (stat_q),
      .info_word (info_q),
      .ready     (ent_ready),
      .valid     (ent_valid),
      .ptr       (ent_ptr),
      .len       (ent_len),
      .eof       (ent_eof),
      .info      (ent_info)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         base       <= '0;
         next_ptr   <= '0;
         info_q     <= '0;
         stat_q     <= '0;
         idx        <= '0;
         nblk       <= CNT_W'(1);
         ext_q      <= 1'b0;
         req_sent   <= 1'b0;
         err        <= 1'b0;
         irq_frame  <= 1'b0;
         irq_refill <= 1'b0;
      end else begin
         irq_frame  <= 1'b0;
         irq_refill <= 1'b0;
         unique case (st)
            ST_IDLE, ST_HALT: begin
               if (start) begin
                  err      <= 1'b0;
                  base     <= start_addr;
                  nblk     <= (blk_cfg == '0) ? CNT_W'(1) : blk_cfg;
                  ext_q    <= extract;
                  idx      <= '0;
                  req_sent <= 1'b0;
                  if (|start_addr[2:0]) begin
                     err <= 1'b1;
                     st  <= ST_HALT;
                  end else begin
                     st  <= ST_NEXT;
                  end
               end
            end
            ST_NEXT, ST_INFO, ST_STAT, ST_PTR: begin
               if (!req_sent) begin
                  req_sent <= 1'b1;
               end else if (rd_valid) begin
                  req_sent <= 1'b0;
                  case (st)
                     ST_NEXT: begin
                        next_ptr <= rd_data[AW-1:0];
                        st       <= ST_INFO;
                     end
                     ST_INFO: begin
                        info_q <= rd_data;
                        st     <= ST_STAT;
                     end
                     ST_STAT: begin
                        stat_q <= rd_data;
                        st     <= ST_PTR;
                     end
                     default: begin
                        if (blk_bad) begin
                           err <= 1'b1;
                           st  <= ST_HALT;
                        end else begin
                           st  <= ST_OUT;
                        end
                     end
                  endcase
               end
            end
            ST_OUT: begin
               if (acc) begin
                  irq_frame <= ent_eof;
                  if (!last_blk) begin
                     idx <= idx + 1'b1;
                     st  <= ST_STAT;
                  end else if (&next_ptr) begin
                     irq_refill <= 1'b1;
                     st         <= ST_IDLE;
                  end else if (|next_ptr[2:0]) begin
                     err <= 1'b1;
                     st  <= ST_HALT;
                  end else begin
                     base <= next_ptr;
                     idx  <= '0;
                     st   <= ST_NEXT;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/desc_walker_chk.sv
module desc_walker_chk #(
   parameter int unsigned AW    = 32,
   parameter int unsigned LEN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_req,
   input logic [AW-1:0]    rd_addr,
   input logic             ent_valid,
   input logic             ent_ready,
   input logic [AW-1:0]    ent_ptr,
   input logic [LEN_W-1:0] ent_len,
   input logic             ent_eof,
   input logic             irq_frame,
   input logic             irq_refill,
   input logic             err,
   input logic             busy
);
   // R2
   addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_addr[2:0] == 3'b000));

   // R4
   entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_valid && !ent_ready) |=> (ent_valid && $stable(ent_ptr) && $stable(ent_len) && $stable(ent_eof)));

   // R5
   no_read_while_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid |-> !rd_req);

   // R8
   frame_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_frame |-> $past(ent_valid && ent_ready && ent_eof));

   // R7
   refill_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_refill |-> (!busy && !err));

   // R9
   halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !rd_req && !ent_valid));
endmodule

bind desc_walker desc_walker_chk #(.AW(AW), .LEN_W(LEN_W)) u_walk_chk (.*);

// File: tb/desc_walker_test.sv
module desc_walker_test;
   localparam int unsigned AW = 32;
   localparam int unsigned DW = 64;
   localparam logic [63:0] ONES = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [3:0]    blk_cfg = '0;
   logic          extract = 1'b0;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic          ent_valid;
   logic          ent_ready = 1'b1;
   logic [AW-1:0] ent_ptr;
   logic [15:0]   ent_len;
   logic          ent_eof;
   logic [DW-1:0] ent_info;
   logic          irq_frame;
   logic          irq_refill;
   logic          err;
   logic          busy;

   always #10 clk = ~clk;

   desc_walker uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .blk_cfg(blk_cfg), .extract(extract), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .ent_valid(ent_valid),
      .ent_ready(ent_ready), .ent_ptr(ent_ptr), .ent_len(ent_len),
      .ent_eof(ent_eof), .ent_info(ent_info), .irq_frame(irq_frame),
      .irq_refill(irq_refill), .err(err), .busy(busy)
   );

   logic [63:0] mem [0:255];

   always_ff @(posedge clk) begin
      rd_valid <= rd_req;
      rd_data  <= mem[rd_addr[10:3]];
   end

   int          n_chk = 0;
   int          n_bad = 0;
   int          n_ent, n_req, n_frm, n_ref, n_rd_in_offer;
   logic [31:0] got_ptr [0:31];
   logic [15:0] got_len [0:31];
   logic        got_eof [0:31];
   logic [31:0] req_addr [0:63];

   always @(posedge clk) begin
      if (rst_n) begin
         if (ent_valid && ent_ready && n_ent < 32) begin
            got_ptr[n_ent] = ent_ptr;
            got_len[n_ent] = ent_len;
            got_eof[n_ent] = ent_eof;
            n_ent = n_ent + 1;
         end
         if (rd_req && n_req < 64) begin
            req_addr[n_req] = rd_addr;
            n_req = n_req + 1;
         end
         if (rd_req && ent_valid) n_rd_in_offer = n_rd_in_offer + 1;
         if (irq_frame) n_frm = n_frm + 1;
         if (irq_refill) n_ref = n_ref + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [63:0] nxt, input int n,
                           input logic [31:0] pbase, input logic [15:0] len, input bit eof_last);
      mem[a[10:3]]     = nxt;
      mem[a[10:3] + 1] = 64'hA5A5_0000_0000_0000 | 64'(a);
      for (int i = 0; i < n; i++) begin
         mem[a[10:3] + 2 + 2*i] = {47'd0, (eof_last && i == n-1), len};
         mem[a[10:3] + 3 + 2*i] = {32'd0, pbase + 32'(i*64)};
      end
   endtask

   task automatic clr();
      n_ent = 0; n_req = 0; n_frm = 0; n_ref = 0; n_rd_in_offer = 0;
   endtask

   task automatic go(input logic [31:0] a, input logic [3:0] cfg, input bit ext);
      @(negedge clk);
      start = 1'b1; start_addr = a; blk_cfg = cfg; extract = ext;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!busy && !err && !rd_req && !ent_valid && !irq_frame && !irq_refill,
          "R1 reset state", {busy, err, rd_req, ent_valid, irq_frame, irq_refill}, 0);
   endtask

   task automatic t_single();
      put_desc(32'h100, ONES, 2, 32'h8000, 16'd60, 1'b1);
      clr(); go(32'h100, 4'd2, 1'b0); wait_idle();
      chk(n_req == 6, "R2 read count", n_req, 6);
      for (int i = 0; i < 6; i++)
         chk(req_addr[i] == 32'h100 + 32'(8*i), "R2 read address order", req_addr[i], 32'h100 + 32'(8*i));
      chk(n_ent == 2, "R4 entries", n_ent, 2);
      chk(got_ptr[1] == 32'h8040 && got_len[1] == 16'd60 && got_eof[1], "R4 entry fields", got_ptr[1], 32'h8040);
      chk(!got_eof[0], "R4 eof clear on first", got_eof[0], 0);
      chk(n_frm == 1, "R8 frame irq count", n_frm, 1);
      chk(n_ref == 1 && !busy, "R7 refill irq and idle", n_ref, 1);
   endtask

   task automatic t_chain_zero_cfg();
      put_desc(32'h200, 64'h300, 1, 32'h9000, 16'd10, 1'b0);
      put_desc(32'h300, ONES, 1, 32'hA000, 16'd20, 1'b1);
      clr(); go(32'h200, 4'd0, 1'b0); wait_idle();
      chk(n_ent == 2, "R3 cfg 0 as one block", n_ent, 2);
      chk(n_req == 8, "R3 reads per block", n_req, 8);
      chk(req_addr[4] == 32'h300, "R6 follow next pointer", req_addr[4], 32'h300);
      chk(got_ptr[1] == 32'hA000 && got_len[1] == 16'd20, "R6 second block entry", got_ptr[1], 32'hA000);
      chk(n_frm == 1 && n_ref == 1, "R8 one frame one refill", {n_frm, n_ref}, 64'h1_0000_0001);
   endtask

   task automatic t_max_cfg();
      put_desc(32'h400, ONES, 15, 32'hB000, 16'd8, 1'b1);
      clr(); go(32'h400, 4'd15, 1'b0); wait_idle();
      chk(n_ent == 15, "R3 fifteen blocks", n_ent, 15);
      chk(got_ptr[14] == 32'hB000 + 32'(14*64) && got_eof[14], "R3 last block", got_ptr[14], 32'hB000 + 32'(14*64));
      chk(req_addr[31] == 32'h4F8, "R2 last read address", req_addr[31], 32'h4F8);
   endtask

   task automatic t_stall();
      logic [31:0] p0;
      put_desc(32'h100, ONES, 2, 32'h8000, 16'd60, 1'b1);
      clr(); ent_ready = 1'b0; go(32'h100, 4'd2, 1'b0);
      for (int i = 0; i < 100 && !ent_valid; i++) @(negedge clk);
      p0 = ent_ptr;
      repeat (5) @(negedge clk);
      chk(ent_valid && ent_ptr == p0, "R4 held while stalled", ent_ptr, p0);
      chk(n_rd_in_offer == 0 && n_req == 4, "R5 no read while offering", n_req, 4);
      ent_ready = 1'b1; wait_idle();
      chk(n_ent == 2, "R5 resumes after accept", n_ent, 2);
   endtask

   task automatic t_extract();
      put_desc(32'h600, ONES, 1, 32'hC000, 16'd256, 1'b1);
      clr(); go(32'h600, 4'd1, 1'b1); wait_idle();
      chk(!err && n_ent == 1, "R10 extraction legal block", {err, n_ent}, 1);
      put_desc(32'h600, ONES, 1, 32'hC004, 16'd256, 1'b1);
      clr(); go(32'h600, 4'd1, 1'b1); wait_idle();
      chk(err && n_ent == 0 && n_ref == 0, "R10 extraction misaligned ptr", {err, n_ent}, 64'h1_0000_0000);
      put_desc(32'h600, ONES, 1, 32'hC000, 16'd200, 1'b1);
      clr(); go(32'h600, 4'd1, 1'b1); wait_idle();
      chk(err && n_ent == 0, "R10 extraction bad length", {err, n_ent}, 64'h1_0000_0000);
      put_desc(32'h600, ONES, 1, 32'hC004, 16'd100, 1'b1);
      clr(); go(32'h600, 4'd1, 1'b0); wait_idle();
      chk(!err && n_ent == 1 && got_len[0] == 16'd100, "R10 injection unchecked", {err, n_ent}, 1);
   endtask

   task automatic t_misalign();
      clr(); go(32'h104, 4'd1, 1'b0); wait_idle();
      chk(err && n_req == 0 && !busy, "R9 misaligned start", {err, n_req}, 64'h1_0000_0000);
      repeat (5) @(negedge clk);
      chk(err, "R9 err sticky", err, 1);
      put_desc(32'h700, 64'h30C, 1, 32'hD000, 16'd8, 1'b0);
      clr(); go(32'h700, 4'd1, 1'b0); wait_idle();
      chk(err && n_ent == 1 && n_req == 4, "R9 misaligned next pointer", {n_ent, n_req}, 64'h1_0000_0004);
   endtask

   task automatic t_restart();
      put_desc(32'h100, ONES, 2, 32'h8000, 16'd60, 1'b1);
      put_desc(32'h300, ONES, 1, 32'hA000, 16'd20, 1'b1);
      clr(); go(32'h100, 4'd2, 1'b0);
      @(negedge clk);
      chk(!err, "R11 start clears err", err, 0);
      wait_idle();
      chk(n_ent == 2, "R11 walk after halt", n_ent, 2);
      clr(); ent_ready = 1'b0; go(32'h100, 4'd2, 1'b0);
      for (int i = 0; i < 100 && !ent_valid; i++) @(negedge clk);
      go(32'h300, 4'd1, 1'b0);
      ent_ready = 1'b1; wait_idle();
      chk(n_ent == 2 && got_ptr[0] == 32'h8000 && got_ptr[1] == 32'h8040,
          "R11 start ignored while busy", got_ptr[1], 32'h8040);
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      clr();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_single();
      t_chain_zero_cfg();
      t_max_cfg();
      t_stall();
      t_extract();
      t_misalign();
      t_restart();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule